// File: doc/BRIEF.md
# Protection Region Matcher with Subregions

This block decides which of eight configured memory protection regions covers an incoming access address. Each region is a naturally aligned power-of-two window of at least 32 bytes, described by a base address, a size code, an enable bit, an eight-bit subregion mask and a set of attribute bits. The configuration arrives as flat vectors from a register bank. The address arrives together with its privilege level. The block returns a hit flag, the index of the winning region, that region's attribute bits and a fault flag.

A window of 256 bytes or more is cut into eight equal slices. Any slice can be removed through the mask. An address inside a removed slice does not belong to that region. A lower-numbered region that overlaps the slice can then claim the address. If no other region claims it, the access is treated as a miss. For smaller windows the mask is ignored. Among several matching regions the highest index wins. A miss faults unless the access is privileged and the background region is enabled. The match logic is combinational. A parameter adds one output register stage.

Top module: `prot_region_matcher`

## Requirements
- R1: A region of size code N covers 2^(N+1) bytes. Code values 0 to 3 act as 4, so the smallest window is 32 bytes. An enabled region matches when every address bit from N+1 upward equals the same bit of its base.
- R2: When N is 7 or more, address bits [N:N-2] select subregion i. Mask bit i set removes that slice, so bit 0 removes the lowest-addressed eighth and bit 7 removes the highest.
- R3: An address in a removed slice may be claimed by an overlapping lower-numbered region. Example: a 512 KB region with mask 0b00000011 sits over a 128 KB region with the same base. The 128 KB region then wins over the first 128 KB, and the larger region wins above it.
- R4: For size codes 4 to 6 (32, 64 and 128 bytes) the mask is ignored and treated as all zeros.
- R5: When several enabled regions match, the highest index wins. hit_idx gives that index and attr_o gives its attribute bits.
- R6: A miss that is unprivileged, or that occurs with the background region disabled, gives fault=1, hit=0, hit_idx=0 and attr_o=DEF_ATTR.
- R7: A privileged miss with the background region enabled gives hit=0, fault=0, hit_idx=0 and attr_o=DEF_ATTR.
- R8: With the global enable low, every access gives hit=0, fault=0, hit_idx=0 and attr_o=DEF_ATTR, whatever the configuration.
- R9: With OUT_REG=1, the outputs reflect the inputs sampled at the previous rising clock edge. A synchronous high reset clears all outputs to zero.
- R10: A region whose enable bit is 0 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global protection enable |
| bg_en | input | 1 | Background region enable for privileged misses |
| priv | input | 1 | Access is privileged |
| addr | input | AW | Access address |
| cfg_en | input | NREG | Per-region enable |
| cfg_base | input | NREG*AW | Per-region base address, region i at [i*AW +: AW] |
| cfg_size | input | NREG*5 | Per-region size code N |
| cfg_srd | input | NREG*8 | Per-region subregion disable mask |
| cfg_attr | input | NREG*ATTR_W | Per-region attribute bits |
| hit | output | 1 | An enabled region matched |
| hit_idx | output | 3 | Index of the winning region |
| attr_o | output | ATTR_W | Attributes of the winner, or DEF_ATTR |
| fault | output | 1 | Access is refused |

## Verification
Directed cases place addresses on both sides of a region edge and inside removed and kept slices, at the smallest window that supports slices (256 bytes). These cases tell mask decoding apart from plain range compare and confirm the bit-0-is-lowest order. The stacked 512 KB / 128 KB layout separates priority from slice removal: the winner must change exactly at the 128 KB line. Small windows given an all-ones mask show whether the mask is wrongly applied below 256 bytes. Random configurations with addresses steered into chosen regions, under mixed privilege, background and global enables, exercise overlap priority and the miss and fault rules against a reference model built on arithmetic range compare.

// File: rtl/prm_pkg.sv
package prm_pkg;
  localparam int SZW   = 5;
  localparam int SRDW  = 8;
  localparam int MINSZ = 4;
  localparam int SUBSZ = 7;
endpackage

// File: rtl/prm_region.sv
module prm_region
  import prm_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]   addr,
  input  logic [AW-1:0]   base,
  input  logic [SZW-1:0]  size,
  input  logic [SRDW-1:0] srd,
  input  logic            en,
  output logic            match
);
  logic [SZW-1:0] n_eff;
  logic [AW:0]    low_mask;
  logic [AW-1:0]  shifted;
  logic [2:0]     sub_idx;
  logic           in_win;
  logic           sub_off;

  always_comb begin
    n_eff    = (size < SZW'(MINSZ)) ? SZW'(MINSZ) : size;
    low_mask = ({{AW{1'b0}}, 1'b1} << (int'(n_eff) + 1)) - 1'b1;
    in_win   = (((addr ^ base) & ~low_mask[AW-1:0]) == '0);
    shifted  = addr >> (n_eff - SZW'(2));
    sub_idx  = shifted[2:0];
    sub_off  = (n_eff >= SZW'(SUBSZ)) && srd[sub_idx];
    match    = en && in_win && !sub_off;
  end
endmodule

// File: rtl/prm_arbiter.sv
module prm_arbiter #(
  parameter int NREG   = 8,
  parameter int ATTR_W = 8,
  localparam int IW    = $clog2(NREG)
) (
  input  logic [NREG-1:0]        match_vec,
  input  logic [NREG*ATTR_W-1:0] attr_flat,
  output logic                   any,
  output logic [IW-1:0]          idx,
  output logic [ATTR_W-1:0]      attr
);
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    attr = '0;
    for (int i = 0; i < NREG; i++) begin
      if (match_vec[i]) begin
        any  = 1'b1;
        idx  = IW'(i);
        attr = attr_flat[i*ATTR_W +: ATTR_W];
      end
    end
  end
endmodule

// File: rtl/prot_region_matcher.sv
module prot_region_matcher
  import prm_pkg::*;
#(
  parameter int              AW       = 32,
  parameter int              NREG     = 8,
  parameter int              ATTR_W   = 8,
  parameter logic [ATTR_W-1:0] DEF_ATTR = 8'h3C,
  parameter bit              OUT_REG  = 1'b1,
  localparam int             IW       = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   glb_en,
  input  logic                   bg_en,
  input  logic                   priv,
  input  logic [AW-1:0]          addr,
  input  logic [NREG-1:0]        cfg_en,
  input  logic [NREG*AW-1:0]     cfg_base,
  input  logic [NREG*SZW-1:0]    cfg_size,
  input  logic [NREG*SRDW-1:0]   cfg_srd,
  input  logic [NREG*ATTR_W-1:0] cfg_attr,
  output logic                   hit,
  output logic [IW-1:0]          hit_idx,
  output logic [ATTR_W-1:0]      attr_o,
  output logic                   fault
);
  logic [NREG-1:0]   match_vec;
  logic              arb_any;
  logic [IW-1:0]     arb_idx;
  logic [ATTR_W-1:0] arb_attr;
  logic              hit_c, fault_c;
  logic [IW-1:0]     idx_c;
  logic [ATTR_W-1:0] attr_c;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    prm_region #(.AW(AW)) u_region (
      .addr  (addr),
      .base  (cfg_base[g*AW +: AW]),
      .size  (cfg_size[g*SZW +: SZW]),
      .srd   (cfg_srd[g*SRDW +: SRDW]),
      .en    (cfg_en[g]),
      .match (match_vec[g])
    );
  end

  prm_arbiter #(.NREG(NREG), .ATTR_W(ATTR_W)) u_arb (
    .match_vec (match_vec),
    .attr_flat (cfg_attr),
    .any       (arb_any),
    .idx       (arb_idx),
    .attr      (arb_attr)
  );

  always_comb begin
    hit_c   = glb_en && arb_any;
    idx_c   = hit_c ? arb_idx : '0;
    attr_c  = hit_c ? arb_attr : DEF_ATTR;
    fault_c = glb_en && !arb_any && (!priv || !bg_en);
  end

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk) begin
      if (rst) begin
        hit     <= 1'b0;
        hit_idx <= '0;
        attr_o  <= '0;
        fault   <= 1'b0;
      end else begin
        hit     <= hit_c;
        hit_idx <= idx_c;
        attr_o  <= attr_c;
        fault   <= fault_c;
      end
    end
  end else begin : g_comb
    always_comb begin
      hit     = hit_c;
      hit_idx = idx_c;
      attr_o  = attr_c;
      fault   = fault_c;
    end
  end

  // R5
  winner_matches_chk: assert property (@(posedge clk) disable iff (rst)
    arb_any |-> match_vec[arb_idx]);
  // R5
  no_higher_match_chk: assert property (@(posedge clk) disable iff (rst)
    arb_any |-> ((match_vec >> arb_idx) == 1));
  // R6
  fault_excl_hit_chk: assert property (@(posedge clk) disable iff (rst)
    fault_c |-> !hit_c);
  // R8
  glb_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !glb_en |-> (!hit_c && !fault_c && attr_c == DEF_ATTR));
  // R10
  off_region_silent_chk: assert property (@(posedge clk) disable iff (rst)
    ((match_vec & ~cfg_en) == '0));
endmodule

// File: tb/prot_region_matcher_tb.sv
`timescale 1ns/1ps
module prot_region_matcher_tb;
  localparam int AW = 32, NREG = 8, AT = 8;
  localparam logic [AT-1:0] DEF = 8'h3C;

  logic clk = 1'b0, rst = 1'b1;
  logic glb_en, bg_en, priv;
  logic [AW-1:0] addr;
  logic [NREG-1:0] cen;
  logic [NREG*AW-1:0] cbase;
  logic [NREG*5-1:0] csize;
  logic [NREG*8-1:0] csrd;
  logic [NREG*AT-1:0] cattr;
  logic hit, fault;
  logic [2:0] hidx;
  logic [AT-1:0] attr;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  prot_region_matcher #(.AW(AW), .NREG(NREG), .ATTR_W(AT), .DEF_ATTR(DEF), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst(rst), .glb_en(glb_en), .bg_en(bg_en), .priv(priv), .addr(addr),
    .cfg_en(cen), .cfg_base(cbase), .cfg_size(csize), .cfg_srd(csrd), .cfg_attr(cattr),
    .hit(hit), .hit_idx(hidx), .attr_o(attr), .fault(fault));

  // expected {hit, idx, attr, fault}, arithmetic range model
  function automatic logic [12:0] model(input logic [AW-1:0] a);
    logic h = 1'b0; logic [2:0] ix = 0; logic [AT-1:0] at = DEF; logic f;
    for (int i = 0; i < NREG; i++) begin
      int n = int'(csize[i*5 +: 5]);
      longint unsigned sz, lo, sub;
      if (n < 4) n = 4;
      sz  = 64'd1 << (n + 1);
      lo  = longint'(cbase[i*AW +: AW]) & ~(sz - 1);
      if (cen[i] && longint'(a) >= lo && longint'(a) < lo + sz) begin
        sub = (longint'(a) - lo) / (sz / 8);
        if (!(sz >= 256 && csrd[i*8 + int'(sub)])) begin
          h = 1'b1; ix = 3'(i); at = cattr[i*AT +: AT];
        end
      end
    end
    if (!glb_en) begin h = 0; ix = 0; at = DEF; end
    f = glb_en && !h && (!priv || !bg_en);
    return {h, ix, at, f};
  endfunction

  task automatic cmp(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h act{hit,idx,attr,fault}=%h exp=%h", req, addr, act, exp);
    end
  endtask

  task automatic probe(input string req, input logic [AW-1:0] a, input logic p);
    logic [12:0] e;
    addr = a; priv = p;
    e = model(a);
    @(posedge clk); @(negedge clk);
    cmp(req, {hit, hidx, attr, fault}, e);
  endtask

  task automatic set_reg(input int i, input logic e, input logic [AW-1:0] b,
                         input logic [4:0] s, input logic [7:0] m, input logic [AT-1:0] at);
    cen[i] = e; cbase[i*AW +: AW] = b; csize[i*5 +: 5] = s;
    csrd[i*8 +: 8] = m; cattr[i*AT +: AT] = at;
  endtask

  task automatic clear_all();
    cen = '0; cbase = '0; csize = '0; csrd = '0; cattr = '0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    clear_all(); glb_en = 1; bg_en = 1; priv = 0; addr = '0;
    repeat (3) @(negedge clk);
    // R9 reset clears outputs
    cmp("R9 reset", {hit, hidx, attr, fault}, 13'h0);
    rst = 0;

    // R1 basic window, 1 KB at 0x4000_0000
    set_reg(3, 1, 32'h4000_0000, 5'd9, 8'h00, 8'hA1);
    probe("R1 inside low", 32'h4000_0000, 0);
    probe("R1 inside top", 32'h4000_03FF, 0);
    cmp("R1 hit literal", {hit, hidx, attr, fault}, {1'b1, 3'd3, 8'hA1, 1'b0});
    probe("R1 above edge", 32'h4000_0400, 0);
    cmp("R6 literal fault", {hit, hidx, attr, fault}, {1'b0, 3'd0, DEF, 1'b1});
    // R1 small code acts as 32 B
    set_reg(4, 1, 32'h5000_0000, 5'd1, 8'h00, 8'hB2);
    probe("R1 code1 top", 32'h5000_001F, 0);
    probe("R1 code1 out", 32'h5000_0020, 0);
    // R10 disabled region
    cen[3] = 0;
    probe("R10 disabled", 32'h4000_0010, 0);
    cmp("R10 literal", hit, 1'b0);
    // R7 privileged miss with background
    probe("R7 priv miss", 32'h4000_0010, 1);
    cmp("R7 literal", {hit, hidx, attr, fault}, {1'b0, 3'd0, DEF, 1'b0});
    bg_en = 0;
    probe("R6 bg off", 32'h4000_0010, 1);
    bg_en = 1;

    // R2 256 B region, slice order
    clear_all();
    set_reg(2, 1, 32'h0000_1000, 5'd7, 8'h80, 8'hC3);
    probe("R2 slice7 off", 32'h0000_10E0, 0);
    cmp("R2 slice7 literal", hit, 1'b0);
    probe("R2 slice6 on", 32'h0000_10DF, 0);
    cmp("R2 slice6 literal", hit, 1'b1);
    csrd[2*8 +: 8] = 8'h01;
    probe("R2 slice0 off", 32'h0000_1000, 0);
    probe("R2 slice1 on", 32'h0000_1020, 0);

    // R4 small windows ignore mask
    set_reg(5, 1, 32'h0000_2000, 5'd5, 8'hFF, 8'hD4);
    probe("R4 64B mask ignored", 32'h0000_2030, 0);
    cmp("R4 literal", {hit, hidx}, {1'b1, 3'd5});
    set_reg(6, 1, 32'h0000_3000, 5'd6, 8'hFF, 8'hE5);
    probe("R4 128B mask ignored", 32'h0000_307F, 0);

    // R3 stacked example, 512 KB over 128 KB
    clear_all();
    set_reg(1, 1, 32'h2000_0000, 5'd16, 8'h00, 8'h11);
    set_reg(2, 1, 32'h2000_0000, 5'd18, 8'h03, 8'h22);
    probe("R3 low part", 32'h2001_0000, 0);
    cmp("R3 low literal", {hidx, attr}, {3'd1, 8'h11});
    probe("R3 last byte small", 32'h2001_FFFF, 0);
    probe("R3 above", 32'h2002_0000, 0);
    cmp("R3 above literal", {hidx, attr}, {3'd2, 8'h22});
    csrd[2*8 +: 8] = 8'h00;
    probe("R5 big wins", 32'h2000_0100, 0);
    cmp("R5 literal", hidx, 3'd2);

    // R8 global off
    glb_en = 0;
    probe("R8 glb off", 32'h2000_0100, 0);
    cmp("R8 literal", {hit, hidx, attr, fault}, {1'b0, 3'd0, DEF, 1'b0});
    glb_en = 1;

    // R5 random mix
    for (int t = 0; t < 3000; t++) begin
      logic [AW-1:0] a;
      int j;
      if (t % 50 == 0) begin
        for (int i = 0; i < NREG; i++) begin
          int s = ($urandom % 4 == 0) ? 4 + $urandom % 28 : 4 + $urandom % 12;
          set_reg(i, ($urandom % 8) != 0, $urandom, 5'(s), 8'($urandom), 8'($urandom));
        end
      end
      j = $urandom % NREG;
      a = ($urandom % 5 == 0) ? $urandom : (cbase[j*AW +: AW] ^ ($urandom & 32'h0000_0FFF));
      glb_en = ($urandom % 10) != 0;
      bg_en  = $urandom;
      probe("R5 random", a, 1'($urandom));
    end

    // R9 reset mid-run
    rst = 1;
    @(posedge clk); @(negedge clk);
    cmp("R9 reset again", {hit, hidx, attr, fault}, 13'h0);
    rst = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule